// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an asynchronous serial line into parallel characters. It counts a sample-rate enable that runs at sixteen times the bit rate. When the line falls from mark to space, the block checks the line again half a bit later to confirm the start bit. It then samples each data bit, the optional parity bit and one stop bit at the centre of the bit. The finished character goes into a holding register, and a ready flag tells the consumer that a character is waiting.

Each completed character updates three error flags: parity, framing and overrun. A line held at space for a whole character is a break. A break gives a single all-zero character and raises a break indicator. The receiver then ignores the line until it returns to mark. A missing stop bit followed by a space that lasts one more bit is taken as the start bit of the next character.

The surrounding logic supplies the sample enable, a receive enable, an active-low carrier input and the character format. It reads the character by pulsing a read strobe.

Top module: `uart_os_rx`

## Requirements
- R1: The receiver works only while `rxEnable`=1 and `carrierN`=0. Otherwise no character is accepted and `rxReady` is cleared. After it is re-enabled, the receiver waits for mark before it looks for a start bit.
- R2: A space that is no longer present 8 ticks after the falling edge is treated as noise. The receiver goes back to searching and delivers no character.
- R3: Data bits arrive LSB first, each sampled 16 ticks after the previous sample. `charLen` sets the length: 0=5, 1=6, 2=7, 3=8 bits. On completion, `rxData` holds the character with its unused high bits at zero, and `rxReady` is set.
- R4: When `parityEn`=1, one parity bit follows the data. `parityOdd`=1 selects odd parity and 0 selects even. `parityErr` is set when the received parity bit does not match the selected parity.
- R5: A stop bit sampled at space sets `framingErr`, and the character is still delivered.
- R6: After a missing stop bit, a line still at space one bit time later is taken as a start bit that has already been validated, and the next character is assembled from there.
- R7: If the start bit, every data bit, the parity bit (when enabled) and the stop bit are all space, that is a break. Exactly one all-zero character is delivered with `framingErr`=1, and no further start bit is accepted until the line returns to mark.
- R8: `breakDet` rises when a break character is delivered. It falls on the first tick at which the line is at mark.
- R9: `overrunErr` is set when a character completes while `rxReady` is still set and no read is happening in that cycle. The new character replaces the old one.
- R10: A pulse on `readStrobe` clears `rxReady` on the next clock edge.
- R11: Each completed character rewrites all three error flags, so a clean character clears errors left by the one before it. Reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleTick | input | 1 | Enable at sixteen times the bit rate |
| rxLine | input | 1 | Serial line, 1 = mark |
| rxEnable | input | 1 | Receiver enable |
| carrierN | input | 1 | Carrier detect, active low |
| charLen | input | 2 | Character length: 5 + value |
| parityEn | input | 1 | Parity bit present |
| parityOdd | input | 1 | 1 = odd parity, 0 = even parity |
| readStrobe | input | 1 | Consumer read of the holding register |
| rxData | output | 8 | Holding register |
| rxReady | output | 1 | Character waiting |
| parityErr | output | 1 | Parity error of the latest character |
| framingErr | output | 1 | Framing error of the latest character |
| overrunErr | output | 1 | Latest character overwrote an unread one |
| breakDet | output | 1 | Break in progress |

## Verification
A tick counter that is off by one moves every sample toward a bit edge. With alternating data patterns this shows up as wrong bits in `rxData` in the very first character. A wrong bit-count or shift alignment shows as a bad value or nonzero high bits when the character completes. A controller that misses the wait-for-mark state after a break shows a second `rxReady` within one character time of clearing the first. A wrong resynchronization target corrupts the character that follows a framing error. This appears at that character's completion, about ten bit times later.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;

  typedef enum logic [2:0] {
    ST_WAITMARK,
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP,
    ST_RESYNC
  } rxState_t;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic shiftData;
    logic captureParity;
    logic loadChar;
    logic breakChar;
    logic dropReady;
    logic sampleVal;
  } rxStrobe_t;

endpackage

// File: rtl/uart_os_rx_ctrl.sv
module uart_os_rx_ctrl
  import uart_os_rx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int MIN_LEN    = 5,
  parameter int OVERSAMPLE = 16,
  localparam int LEN_SEL_W = $clog2(DATA_W - MIN_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleTick,
  input  logic                 rxLine,
  input  logic                 rxEnable,
  input  logic                 carrierN,
  input  logic [LEN_SEL_W-1:0] charLen,
  input  logic                 parityEn,
  output rxStrobe_t            strb,
  output logic                 breakDet
);

  localparam int CW    = $clog2(OVERSAMPLE);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CW-1:0] LAST_TICK = CW'(OVERSAMPLE - 1);
  localparam logic [CW-1:0] HALF_TICK = CW'(OVERSAMPLE / 2 - 1);

  rxState_t         state;
  logic [CW-1:0]    cnt;
  logic [BIT_W-1:0] bitIdx;
  logic             sawMark;
  logic             active;
  logic             atEnd;
  logic [BIT_W-1:0] lastIdx;

  assign active  = rxEnable & ~carrierN;
  assign atEnd   = active & sampleTick & (cnt == LAST_TICK);
  assign lastIdx = BIT_W'(MIN_LEN - 1) + BIT_W'(charLen);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_WAITMARK;
      cnt      <= '0;
      bitIdx   <= '0;
      sawMark  <= 1'b0;
      breakDet <= 1'b0;
    end else if (!active) begin
      state <= ST_WAITMARK;
      cnt   <= '0;
    end else if (sampleTick) begin
      case (state)
        ST_WAITMARK: if (rxLine) begin
          state    <= ST_IDLE;
          breakDet <= 1'b0;
        end
        ST_IDLE: if (!rxLine) begin
          state <= ST_START;
          cnt   <= '0;
        end
        ST_START: begin
          if (cnt == HALF_TICK) begin
            cnt <= '0;
            if (rxLine) state <= ST_IDLE;
            else begin
              state   <= ST_DATA;
              bitIdx  <= '0;
              sawMark <= 1'b0;
            end
          end else cnt <= cnt + 1'b1;
        end
        ST_DATA: begin
          if (cnt == LAST_TICK) begin
            cnt     <= '0;
            sawMark <= sawMark | rxLine;
            if (bitIdx == lastIdx) state <= parityEn ? ST_PARITY : ST_STOP;
            else bitIdx <= bitIdx + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        ST_PARITY: begin
          if (cnt == LAST_TICK) begin
            cnt     <= '0;
            sawMark <= sawMark | rxLine;
            state   <= ST_STOP;
          end else cnt <= cnt + 1'b1;
        end
        ST_STOP: begin
          if (cnt == LAST_TICK) begin
            cnt <= '0;
            if (rxLine) state <= ST_IDLE;
            else if (!sawMark) begin
              breakDet <= 1'b1;
              state    <= ST_WAITMARK;
            end else state <= ST_RESYNC;
          end else cnt <= cnt + 1'b1;
        end
        ST_RESYNC: begin
          if (cnt == LAST_TICK) begin
            cnt <= '0;
            if (rxLine) state <= ST_IDLE;
            else begin
              state   <= ST_DATA;
              bitIdx  <= '0;
              sawMark <= 1'b0;
            end
          end else cnt <= cnt + 1'b1;
        end
        default: state <= ST_WAITMARK;
      endcase
    end
  end

  always_comb begin
    strb               = '0;
    strb.shiftData     = atEnd & (state == ST_DATA);
    strb.captureParity = atEnd & (state == ST_PARITY);
    strb.loadChar      = atEnd & (state == ST_STOP);
    strb.breakChar     = atEnd & (state == ST_STOP) & ~rxLine & ~sawMark;
    strb.dropReady     = ~active;
    strb.sampleVal     = rxLine;
  end

  // R1
  inactive_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> state == ST_WAITMARK);

  // R8
  break_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(breakDet) |-> $past(strb.breakChar));

endmodule

// File: rtl/uart_os_rx_dp.sv
module uart_os_rx_dp
  import uart_os_rx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MIN_LEN = 5,
  localparam int LEN_SEL_W = $clog2(DATA_W - MIN_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rxStrobe_t            strb,
  input  logic [LEN_SEL_W-1:0] charLen,
  input  logic                 parityEn,
  input  logic                 parityOdd,
  input  logic                 readStrobe,
  output logic [DATA_W-1:0]    rxData,
  output logic                 rxReady,
  output logic                 parityErr,
  output logic                 framingErr,
  output logic                 overrunErr
);

  localparam int SH_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] shiftReg;
  logic              parBit;
  logic [SH_W-1:0]   shAmt;
  logic [DATA_W-1:0] assembled;
  logic [DATA_W-1:0] validMask;

  assign shAmt     = SH_W'(DATA_W - MIN_LEN) - SH_W'(charLen);
  assign assembled = shiftReg >> shAmt;
  assign validMask = {DATA_W{1'b1}} >> shAmt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else begin
      if (strb.shiftData)     shiftReg <= {strb.sampleVal, shiftReg[DATA_W-1:1]};
      if (strb.captureParity) parBit   <= strb.sampleVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData     <= '0;
      rxReady    <= 1'b0;
      parityErr  <= 1'b0;
      framingErr <= 1'b0;
      overrunErr <= 1'b0;
    end else if (strb.loadChar) begin
      rxData     <= assembled;
      rxReady    <= 1'b1;
      parityErr  <= parityEn & ((^assembled) ^ parBit ^ parityOdd);
      framingErr <= ~strb.sampleVal;
      overrunErr <= rxReady & ~readStrobe;
    end else if (readStrobe || strb.dropReady) begin
      rxReady <= 1'b0;
    end
  end

  // R9
  overrun_on_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadChar && rxReady && !readStrobe |=> overrunErr);

  // R10
  read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    readStrobe && !strb.loadChar |=> !rxReady);

  // R7
  break_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadChar && strb.breakChar |=> rxData == '0 && framingErr);

  // R3
  high_bits_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadChar |=> (rxData & ~$past(validMask)) == '0);

endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
  import uart_os_rx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int MIN_LEN    = 5,
  parameter int OVERSAMPLE = 16,
  localparam int LEN_SEL_W = $clog2(DATA_W - MIN_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleTick,
  input  logic                 rxLine,
  input  logic                 rxEnable,
  input  logic                 carrierN,
  input  logic [LEN_SEL_W-1:0] charLen,
  input  logic                 parityEn,
  input  logic                 parityOdd,
  input  logic                 readStrobe,
  output logic [DATA_W-1:0]    rxData,
  output logic                 rxReady,
  output logic                 parityErr,
  output logic                 framingErr,
  output logic                 overrunErr,
  output logic                 breakDet
);

  rxStrobe_t strb;

  uart_os_rx_ctrl #(
    .DATA_W(DATA_W), .MIN_LEN(MIN_LEN), .OVERSAMPLE(OVERSAMPLE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .rxEnable(rxEnable), .carrierN(carrierN), .charLen(charLen),
    .parityEn(parityEn), .strb(strb), .breakDet(breakDet)
  );

  uart_os_rx_dp #(
    .DATA_W(DATA_W), .MIN_LEN(MIN_LEN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .charLen(charLen),
    .parityEn(parityEn), .parityOdd(parityOdd), .readStrobe(readStrobe),
    .rxData(rxData), .rxReady(rxReady), .parityErr(parityErr),
    .framingErr(framingErr), .overrunErr(overrunErr)
  );

endmodule

// File: tb/uart_os_rx_bench.sv
module uart_os_rx_bench;

  logic       clk = 1'b0;
  logic       rstN, sampleTick, rxLine, rxEnable, carrierN;
  logic [1:0] charLen;
  logic       parityEn, parityOdd, readStrobe;
  logic [7:0] rxData;
  logic       rxReady, parityErr, framingErr, overrunErr, breakDet;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  uart_os_rx u_uart_os_rx (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .rxEnable(rxEnable), .carrierN(carrierN), .charLen(charLen),
    .parityEn(parityEn), .parityOdd(parityOdd), .readStrobe(readStrobe),
    .rxData(rxData), .rxReady(rxReady), .parityErr(parityErr),
    .framingErr(framingErr), .overrunErr(overrunErr), .breakDet(breakDet)
  );

  typedef struct packed {
    logic [1:0] len;
    logic       parEn;
    logic       parOdd;
    logic       badPar;
    logic [7:0] data;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd3, 1'b0, 1'b0, 1'b0, 8'hA5},
    '{2'd0, 1'b0, 1'b0, 1'b0, 8'hFF},
    '{2'd1, 1'b1, 1'b0, 1'b0, 8'h2C},
    '{2'd2, 1'b1, 1'b1, 1'b0, 8'h5A},
    '{2'd3, 1'b1, 1'b0, 1'b1, 8'h81},
    '{2'd3, 1'b1, 1'b1, 1'b1, 8'h00},
    '{2'd0, 1'b1, 1'b1, 1'b0, 8'h13},
    '{2'd2, 1'b1, 1'b0, 1'b1, 8'h7F}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    rxLine = b;
    repeat (16) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic [1:0] len, input logic pe,
                           input logic po, input logic badPar, input logic stopVal);
    int n = 5 + int'(len);
    logic [7:0] dm = d & (8'hFF >> (3 - int'(len)));
    sendBit(1'b0);
    for (int i = 0; i < n; i++) sendBit(d[i]);
    if (pe) sendBit((^dm) ^ po ^ badPar);
    sendBit(stopVal);
  endtask

  task automatic pulseRead();
    readStrobe = 1'b1;
    @(negedge clk);
    readStrobe = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; sampleTick = 1'b1; rxLine = 1'b1; rxEnable = 1'b1;
    carrierN = 1'b0; charLen = 2'd3; parityEn = 1'b0; parityOdd = 1'b0;
    readStrobe = 1'b0;
    repeat (4) @(negedge clk);
    // R11 reset state
    check("R11 reset outputs", {rxData, rxReady, parityErr, framingErr, overrunErr, breakDet}, '0);
    rstN = 1'b1;
    sendBit(1'b1);

    // R3 R4 table of formats and parity cases
    for (int v = 0; v < 8; v++) begin
      logic [7:0] expD;
      charLen = VEC[v].len; parityEn = VEC[v].parEn; parityOdd = VEC[v].parOdd;
      expD = VEC[v].data & (8'hFF >> (3 - int'(VEC[v].len)));
      sendFrame(VEC[v].data, VEC[v].len, VEC[v].parEn, VEC[v].parOdd, VEC[v].badPar, 1'b1);
      check("R3 ready", rxReady, 1);
      check("R3 data", rxData, expD);
      check("R4 parity flag", parityErr, VEC[v].parEn & VEC[v].badPar);
      check("R5 framing clean", framingErr, 0);
      pulseRead();
      check("R10 read clears ready", rxReady, 0);
      sendBit(1'b1);
    end

    charLen = 2'd3; parityEn = 1'b0; parityOdd = 1'b0;

    // R5 missing stop bit, then a clean character clears it (R11)
    sendFrame(8'h3C, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R5 framing data", rxData, 8'h3C);
    check("R5 framing flag", framingErr, 1);
    sendBit(1'b1);
    pulseRead();
    sendFrame(8'h42, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R11 framing cleared", framingErr, 0);
    check("R11 data", rxData, 8'h42);
    pulseRead();
    sendBit(1'b1);

    // R9 overrun
    sendFrame(8'h11, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    sendBit(1'b1);
    sendFrame(8'h22, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R9 overrun flag", overrunErr, 1);
    check("R9 newest data", rxData, 8'h22);
    pulseRead();
    sendBit(1'b1);
    sendFrame(8'h33, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R11 overrun cleared", overrunErr, 0);
    pulseRead();
    sendBit(1'b1);

    // R2 false start
    rxLine = 1'b0;
    repeat (4) @(negedge clk);
    rxLine = 1'b1;
    repeat (200) @(negedge clk);
    check("R2 glitch ignored", rxReady, 0);
    sendFrame(8'h99, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R2 next char ok", rxData, 8'h99);
    pulseRead();
    sendBit(1'b1);

    // R6 resync after missing stop bit
    sendFrame(8'h55, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R6 first char framing", framingErr, 1);
    sendFrame(8'hC3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R6 resync data", rxData, 8'hC3);
    check("R6 resync framing", framingErr, 0);
    pulseRead();
    sendBit(1'b1);

    // R7 R8 break
    rxLine = 1'b0;
    repeat (11 * 16) @(negedge clk);
    check("R7 break ready", rxReady, 1);
    check("R7 break data", rxData, 8'h00);
    check("R7 break framing", framingErr, 1);
    check("R8 break raised", breakDet, 1);
    pulseRead();
    repeat (20 * 16) @(negedge clk);
    check("R7 single char", rxReady, 0);
    check("R8 break held", breakDet, 1);
    rxLine = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 break dropped", breakDet, 0);
    sendBit(1'b1);
    sendFrame(8'h6E, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R7 after break data", rxData, 8'h6E);
    pulseRead();
    sendBit(1'b1);

    // R1 inactive receiver
    rxEnable = 1'b0;
    sendFrame(8'h77, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    sendBit(1'b1);
    check("R1 disabled no char", rxReady, 0);
    rxEnable = 1'b1;
    sendBit(1'b1);
    carrierN = 1'b1;
    sendFrame(8'h78, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    sendBit(1'b1);
    check("R1 no carrier no char", rxReady, 0);
    carrierN = 1'b0;
    sendBit(1'b1);
    sendFrame(8'h12, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R1 enabled char", rxData, 8'h12);
    carrierN = 1'b1;
    @(negedge clk);
    check("R1 carrier loss clears ready", rxReady, 0);
    carrierN = 1'b0;
    sendBit(1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule